// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel of a packet DMA engine. Software builds a chain of buffer descriptors in a descriptor RAM and starts the channel by writing the address of the first descriptor to the head register. For each descriptor the engine reads four words over a descriptor RAM port. It then streams the referenced bytes from a buffer memory port onto a byte stream with a valid/ready handshake. Finally it writes the status word back with the ownership bit cleared, which returns the descriptor to software.

The channel follows the next pointers until it reaches a descriptor whose next pointer is zero. That descriptor's write-back also sets an end-of-queue flag, and the head register drops to zero. Software appends work to a chain the engine has already left by linking new descriptors behind the old tail. If it then finds the end-of-queue flag set on that tail, it writes the head register again. Each completion is reported through a completion register and a pending output, and software acknowledges a completion by writing the descriptor address back.

Top module: `txdma_chain`

## Requirements
- R1: After reset, all four registers read zero, `cmpl_pend` is low, and no request or stream beat is issued.
- R2: A descriptor is four consecutive 32-bit words, and its pointer is 16-byte aligned, so word k sits at RAM index ptr[DAW+1:2]+k. The words are, in order:
  - the next-descriptor byte address;
  - the buffer byte address;
  - the byte count, in bits [LENW-1:0];
  - the mode word, with start-of-packet at bit 31, end-of-packet at bit 30, ownership at bit 29, end-of-queue at bit 28, and the packet length in bits [10:0].
- R3: The register map uses word index 0 for control (bit 0 enable, bit 1 soft reset), 1 for head, 2 for completion and 3 for status (bit 0 error, bit 1 pending, bit 2 busy). A head write is taken only while the head register reads zero. A taken nonzero head starts the channel only while enable is 1. A head write while busy is ignored.
- R4: The bytes of a buffer leave in ascending address order and stay stable under backpressure. `tx_last` is asserted only on the final byte of a descriptor whose end-of-packet bit is set.
- R5: After the bytes of a descriptor are sent, the engine writes its mode word back with ownership cleared and all other bits kept. This write is the last memory access for that descriptor.
- R6: A nonzero next pointer makes the engine continue with that descriptor, and the head register reads the address of the descriptor in progress.
- R7: When the next pointer is zero, the write-back also sets end-of-queue, and head and busy return to zero. A later head write starts a new chain.
- R8: Each completion loads the completion register with the descriptor address and raises `cmpl_pend`. Writing that same address to the completion register clears `cmpl_pend`, and writing any other value leaves it set.
- R9: A fetched descriptor whose ownership bit is clear is neither transmitted nor written back. The engine sets the error bit and drops head to zero. The next accepted nonzero head write clears the error bit.
- R10: A descriptor with a byte count of zero sends no bytes but is still written back.
- R11: Writing 1 to soft reset makes that bit read 1 for one cycle. The channel is then idle, and head, completion, error and pending are cleared without any write-back.
- R12: Clearing enable during a chain lets the current descriptor finish. The next descriptor is not fetched until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmpl_pend | output | 1 | A completion awaits acknowledgement |
| dr_req | output | 1 | Descriptor RAM read request |
| dr_we | output | 1 | Descriptor RAM write strobe |
| dr_addr | output | DAW | Descriptor RAM word index |
| dr_wdata | output | 32 | Descriptor RAM write data |
| dr_rdata | input | 32 | Descriptor RAM read data, one cycle after the request |
| buf_req | output | 1 | Buffer memory byte read request |
| buf_addr | output | BAW | Buffer byte address |
| buf_rdata | input | 8 | Buffer byte, valid one cycle after the request and held until the next one |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a packet |

## Verification
A wrong captured pointer or byte count shows up at the stream within one descriptor, as missing, extra or reordered bytes compared with the scoreboard. A wrong ownership or end-of-queue decision shows in the mode word written back to descriptor RAM and in the head register as soon as the channel goes idle. A broken enable, error or soft-reset path shows in register reads a cycle or two after the triggering write, and in descriptors whose write-back should or should not have happened.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int SOP_BIT = 31;
  localparam int EOP_BIT = 30;
  localparam int OWN_BIT = 29;
  localparam int EOQ_BIT = 28;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_HEAD = 2'd1;
  localparam logic [1:0] RA_CMPL = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_SRST = 1;
  localparam int STAT_ERR  = 0;
  localparam int STAT_PEND = 1;
  localparam int STAT_BUSY = 2;

  typedef enum logic [2:0] {
    E_IDLE, E_RD1, E_RD2, E_RD3, E_CHK, E_FETCH, E_SEND, E_WB
  } eng_st_t;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eng_adv,
  input  logic [31:0] eng_next,
  input  logic        eng_done,
  input  logic [31:0] eng_done_ptr,
  input  logic        eng_err,
  output logic        ctrl_en,
  output logic        srst,
  output logic [31:0] head,
  output logic        cmpl_pend
);
  logic        en_q, en_d, srst_q, srst_d, pend_q, pend_d, err_q, err_d;
  logic [31:0] head_q, head_d, cmpl_q, cmpl_d;
  logic        wr_ctrl, wr_head, wr_cmpl;

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_head = reg_we && (reg_addr == RA_HEAD);
  assign wr_cmpl = reg_we && (reg_addr == RA_CMPL);

  always_comb begin
    en_d   = en_q;
    srst_d = 1'b0;
    head_d = head_q;
    cmpl_d = cmpl_q;
    pend_d = pend_q;
    err_d  = err_q;
    if (srst_q) begin
      head_d = '0;
      cmpl_d = '0;
      pend_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_d   = reg_wdata[CTRL_EN];
        srst_d = reg_wdata[CTRL_SRST];
      end
      if (eng_adv) begin
        head_d = eng_next;
      end else if (eng_err) begin
        head_d = '0;
        err_d  = 1'b1;
      end else if (wr_head && (head_q == '0)) begin
        head_d = reg_wdata;
        if (reg_wdata != '0) err_d = 1'b0;
      end
      if (eng_done) begin
        cmpl_d = eng_done_ptr;
        pend_d = 1'b1;
      end else if (wr_cmpl && (reg_wdata == cmpl_q)) begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
      head_q <= '0;
      cmpl_q <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      srst_q <= srst_d;
      head_q <= head_d;
      cmpl_q <= cmpl_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CTRL_EN]   = en_q;
        reg_rdata[CTRL_SRST] = srst_q;
      end
      RA_HEAD: reg_rdata = head_q;
      RA_CMPL: reg_rdata = cmpl_q;
      default: begin
        reg_rdata[STAT_ERR]  = err_q;
        reg_rdata[STAT_PEND] = pend_q;
        reg_rdata[STAT_BUSY] = (head_q != '0);
      end
    endcase
  end

  assign ctrl_en   = en_q;
  assign srst      = srst_q;
  assign head      = head_q;
  assign cmpl_pend = pend_q;
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int DAW  = 8,
  parameter int BAW  = 32,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            srst,
  input  logic [31:0]     head,
  output logic            dr_req,
  output logic            dr_we,
  output logic [DAW-1:0]  dr_addr,
  output logic [31:0]     dr_wdata,
  input  logic [31:0]     dr_rdata,
  output logic            buf_req,
  output logic [BAW-1:0]  buf_addr,
  input  logic [7:0]      buf_rdata,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  output logic            eng_adv,
  output logic [31:0]     eng_next,
  output logic            eng_done,
  output logic [31:0]     eng_done_ptr,
  output logic            eng_err
);
  localparam logic [LENW-1:0] CNT_ONE = LENW'(1);

  eng_st_t         st_q, st_d;
  logic [31:0]     cur_q, cur_d, nxt_q, nxt_d, mode_q, mode_d;
  logic [BAW-1:0]  bptr_q, bptr_d;
  logic [LENW-1:0] cnt_q, cnt_d;
  logic            go;
  logic [DAW-1:0]  cur_w, head_w;

  assign go     = en && (head != '0);
  assign cur_w  = cur_q[DAW+1:2];
  assign head_w = head[DAW+1:2];

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    nxt_d  = nxt_q;
    bptr_d = bptr_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (srst) begin
      st_d = E_IDLE;
    end else begin
      case (st_q)
        E_IDLE: if (go) begin
          cur_d = head;
          st_d  = E_RD1;
        end
        E_RD1: begin
          nxt_d = dr_rdata;
          st_d  = E_RD2;
        end
        E_RD2: begin
          bptr_d = dr_rdata[BAW-1:0];
          st_d   = E_RD3;
        end
        E_RD3: begin
          cnt_d = dr_rdata[LENW-1:0];
          st_d  = E_CHK;
        end
        E_CHK: begin
          mode_d = dr_rdata;
          if (!dr_rdata[OWN_BIT])  st_d = E_IDLE;
          else if (cnt_q == '0)    st_d = E_WB;
          else                     st_d = E_FETCH;
        end
        E_FETCH: st_d = E_SEND;
        E_SEND: if (tx_ready) begin
          bptr_d = bptr_q + BAW'(1);
          cnt_d  = cnt_q - CNT_ONE;
          st_d   = (cnt_q == CNT_ONE) ? E_WB : E_FETCH;
        end
        E_WB:    st_d = E_IDLE;
        default: st_d = E_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cur_q  <= '0;
      nxt_q  <= '0;
      bptr_q <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      nxt_q  <= nxt_d;
      bptr_q <= bptr_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    dr_req  = 1'b0;
    dr_addr = cur_w + DAW'(3);
    case (st_q)
      E_IDLE: begin
        dr_req  = go && !srst;
        dr_addr = head_w;
      end
      E_RD1: begin
        dr_req  = !srst;
        dr_addr = cur_w + DAW'(1);
      end
      E_RD2: begin
        dr_req  = !srst;
        dr_addr = cur_w + DAW'(2);
      end
      E_RD3: dr_req = !srst;
      default: ;
    endcase
  end

  always_comb begin
    dr_wdata          = mode_q;
    dr_wdata[OWN_BIT] = 1'b0;
    if (nxt_q == '0) dr_wdata[EOQ_BIT] = 1'b1;
  end

  assign dr_we        = (st_q == E_WB) && !srst;
  assign buf_req      = (st_q == E_FETCH) && !srst;
  assign buf_addr     = bptr_q;
  assign tx_valid     = (st_q == E_SEND);
  assign tx_data      = buf_rdata;
  assign tx_last      = (st_q == E_SEND) && mode_q[EOP_BIT] && (cnt_q == CNT_ONE);
  assign eng_adv      = dr_we;
  assign eng_done     = dr_we;
  assign eng_next     = nxt_q;
  assign eng_done_ptr = cur_q;
  assign eng_err      = (st_q == E_CHK) && !srst && !dr_rdata[OWN_BIT];
endmodule

// File: rtl/txdma_chain.sv
module txdma_chain
  import txdma_pkg::*;
#(
  parameter int DAW  = 8,
  parameter int BAW  = 32,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            cmpl_pend,
  output logic            dr_req,
  output logic            dr_we,
  output logic [DAW-1:0]  dr_addr,
  output logic [31:0]     dr_wdata,
  input  logic [31:0]     dr_rdata,
  output logic            buf_req,
  output logic [BAW-1:0]  buf_addr,
  input  logic [7:0]      buf_rdata,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [7:0]      tx_data,
  output logic            tx_last
);
  logic        rst_s1, rst_s2;
  logic        ctrl_en, srst_pls;
  logic [31:0] head;
  logic        eng_adv, eng_done, eng_err;
  logic [31:0] eng_next, eng_done_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  txdma_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_s2),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .eng_adv      (eng_adv),
    .eng_next     (eng_next),
    .eng_done     (eng_done),
    .eng_done_ptr (eng_done_ptr),
    .eng_err      (eng_err),
    .ctrl_en      (ctrl_en),
    .srst         (srst_pls),
    .head         (head),
    .cmpl_pend    (cmpl_pend)
  );

  txdma_engine #(.DAW(DAW), .BAW(BAW), .LENW(LENW)) u_eng (
    .clk          (clk),
    .rst_n        (rst_s2),
    .en           (ctrl_en),
    .srst         (srst_pls),
    .head         (head),
    .dr_req       (dr_req),
    .dr_we        (dr_we),
    .dr_addr      (dr_addr),
    .dr_wdata     (dr_wdata),
    .dr_rdata     (dr_rdata),
    .buf_req      (buf_req),
    .buf_addr     (buf_addr),
    .buf_rdata    (buf_rdata),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .eng_adv      (eng_adv),
    .eng_next     (eng_next),
    .eng_done     (eng_done),
    .eng_done_ptr (eng_done_ptr),
    .eng_err      (eng_err)
  );
endmodule

// File: rtl/txdma_chain_chk.sv
module txdma_chain_chk #(
  parameter int DAW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           srst,
  input logic           dr_req,
  input logic           dr_we,
  input logic [DAW-1:0] dr_addr,
  input logic [31:0]    dr_wdata,
  input logic           buf_req,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [7:0]     tx_data,
  input logic           tx_last,
  input logic           cmpl_pend
);
  // R5: a write-back always hands the descriptor to software
  a_r5_wb_clears_owner: assert property (@(posedge clk) disable iff (!rst_n)
    dr_we |-> !dr_wdata[29]);

  // R4: a stalled byte holds until taken
  a_r4_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !srst) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4: the last marker only rides on a valid byte
  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R8: every write-back is reported as a pending completion
  a_r8_pend_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    dr_we |=> cmpl_pend);

  // R3: a new descriptor fetch begins only while enabled
  a_r3_fetch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_req && (dr_addr[1:0] == 2'b00)) |-> en);

  // R5: buffer and descriptor accesses never overlap
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    buf_req |-> (!dr_req && !dr_we));
endmodule

bind txdma_chain txdma_chain_chk #(.DAW(DAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (ctrl_en),
  .srst      (srst_pls),
  .dr_req    (dr_req),
  .dr_we     (dr_we),
  .dr_addr   (dr_addr),
  .dr_wdata  (dr_wdata),
  .buf_req   (buf_req),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_last   (tx_last),
  .cmpl_pend (cmpl_pend)
);

// File: tb/txdma_chain_test.sv
`timescale 1ns/1ps
module txdma_chain_test;
  localparam int DAW = 8;
  localparam logic [31:0] F_SOP = 32'h8000_0000;
  localparam logic [31:0] F_EOP = 32'h4000_0000;
  localparam logic [31:0] F_OWN = 32'h2000_0000;
  localparam logic [31:0] F_EOQ = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmpl_pend, dr_req, dr_we, buf_req, tx_valid, tx_ready, tx_last;
  logic [DAW-1:0] dr_addr;
  logic [31:0] dr_wdata, dr_rdata, buf_addr;
  logic [7:0]  buf_rdata, tx_data;

  logic [31:0] dmem [256];
  logic [7:0]  bmem [1024];
  logic [8:0]  expq [$];
  int n_chk = 0, n_bad = 0;
  bit stall = 0, finished = 0;
  logic [7:0] lfsr = 8'h5a;

  always #4 clk = ~clk;

  txdma_chain #(.DAW(DAW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmpl_pend(cmpl_pend),
    .dr_req(dr_req), .dr_we(dr_we), .dr_addr(dr_addr), .dr_wdata(dr_wdata),
    .dr_rdata(dr_rdata), .buf_req(buf_req), .buf_addr(buf_addr),
    .buf_rdata(buf_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last)
  );

  always @(posedge clk) begin
    if (dr_req) dr_rdata <= dmem[dr_addr];
    if (dr_we)  dmem[dr_addr] <= dr_wdata;
    if (buf_req) buf_rdata <= bmem[buf_addr[9:0]];
  end

  // monitor: drives ready away from the edge and scores accepted bytes
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = stall ? (lfsr[0] & lfsr[2]) : 1'b1;
    if (rst_n && tx_valid && tx_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R4: unexpected byte %h last %b, expected none", tx_data, tx_last);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        if ({tx_last, tx_data} !== e) begin
          n_bad++;
          $display("FAIL R4: stream got %h expected %h", {tx_last, tx_data}, e);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 5000; n++) begin
      rd(2'd3, v);
      if (!v[2]) break;
      @(negedge clk);
    end
  endtask

  // driver: lays out a descriptor and queues the bytes it should produce
  task automatic mk_desc(int k, logic [31:0] nxt, int boff, int len,
                         logic [31:0] flags, bit queue_it);
    dmem[4*k]   = nxt;
    dmem[4*k+1] = boff;
    dmem[4*k+2] = len;
    dmem[4*k+3] = flags | (len & 32'h7ff);
    for (int i = 0; i < len; i++) begin
      bmem[boff+i] = 8'((k * 37 + i * 11 + 5) & 8'hff);
      if (queue_it)
        expq.push_back({(i == len - 1) && flags[30], bmem[boff+i]});
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; tx_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 register reset", v, 32'h0);
    end
    chk("R1 pend/valid/req", {31'h0, cmpl_pend | tx_valid | dr_req | buf_req}, 32'h0);

    // single descriptor, end of queue (R2 R4 R5 R7 R8)
    wr(2'd0, 32'h1);
    mk_desc(1, 32'h0, 0, 5, F_SOP | F_EOP | F_OWN, 1);
    wr(2'd1, 32'h10);
    wait_idle();
    chk("R5 R7 R2 write-back word", dmem[7], F_SOP | F_EOP | F_EOQ | 32'd5);
    rd(2'd1, v); chk("R7 head idle", v, 32'h0);
    rd(2'd2, v); chk("R8 completion address", v, 32'h10);
    chk("R8 pending raised", {31'h0, cmpl_pend}, 32'h1);
    chk("R4 all bytes sent", expq.size(), 0);

    // R8 acknowledge
    wr(2'd2, 32'h20);
    chk("R8 wrong ack keeps pending", {31'h0, cmpl_pend}, 32'h1);
    wr(2'd2, 32'h10);
    chk("R8 right ack clears", {31'h0, cmpl_pend}, 32'h0);

    // R3 enable gates start
    wr(2'd0, 32'h0);
    mk_desc(2, 32'h0, 64, 3, F_SOP | F_EOP | F_OWN, 1);
    wr(2'd1, 32'h20);
    repeat (30) @(negedge clk);
    chk("R3 disabled: no bytes", expq.size(), 3);
    rd(2'd1, v); chk("R3 disabled: head held", v, 32'h20);
    chk("R3 disabled: still owned", dmem[11], F_SOP | F_EOP | F_OWN | 32'd3);
    wr(2'd0, 32'h1);
    wait_idle();
    chk("R3 enabled: bytes sent", expq.size(), 0);
    wr(2'd2, 32'h20);

    // R6 chain, packet across two descriptors, backpressure
    stall = 1;
    mk_desc(3, 32'h40, 128, 4, F_SOP | F_OWN, 1);
    mk_desc(4, 32'h50, 160, 6, F_EOP | F_OWN, 1);
    mk_desc(5, 32'h0,  200, 1, F_SOP | F_EOP | F_OWN, 1);
    wr(2'd1, 32'h30);
    wait_idle();
    chk("R6 first write-back no EOQ", dmem[15], F_SOP | 32'd4);
    chk("R6 second write-back no EOQ", dmem[19], F_EOP | 32'd6);
    chk("R7 tail write-back EOQ", dmem[23], F_SOP | F_EOP | F_EOQ | 32'd1);
    rd(2'd2, v); chk("R6 completion is tail", v, 32'h50);
    chk("R4 chain bytes sent", expq.size(), 0);
    wr(2'd2, 32'h50);

    // R10 zero length
    mk_desc(6, 32'h0, 240, 0, F_SOP | F_EOP | F_OWN, 0);
    wr(2'd1, 32'h60);
    wait_idle();
    chk("R10 zero length written back", dmem[27], F_SOP | F_EOP | F_EOQ);
    rd(2'd2, v); chk("R10 completion", v, 32'h60);
    wr(2'd2, 32'h60);

    // R9 owner clear
    mk_desc(7, 32'h0, 260, 4, F_SOP | F_EOP, 0);
    wr(2'd1, 32'h70);
    wait_idle();
    rd(2'd3, v); chk("R9 error set, idle", v, 32'h1);
    chk("R9 no write-back", dmem[31], F_SOP | F_EOP | 32'd4);
    rd(2'd2, v); chk("R9 completion untouched", v, 32'h60);

    // R7 restart clears error
    mk_desc(8, 32'h0, 300, 2, F_SOP | F_EOP | F_OWN, 1);
    wr(2'd1, 32'h80);
    rd(2'd3, v); chk("R9 error cleared by head write", v & 32'h1, 32'h0);
    wait_idle();
    chk("R7 restart completes", dmem[35], F_SOP | F_EOP | F_EOQ | 32'd2);
    wr(2'd2, 32'h80);

    // R3 head write while busy ignored
    mk_desc(9, 32'h0, 340, 24, F_SOP | F_EOP | F_OWN, 1);
    wr(2'd1, 32'h90);
    repeat (10) @(negedge clk);
    wr(2'd1, 32'hA0);
    rd(2'd1, v); chk("R3 busy head write ignored", v, 32'h90);
    wait_idle();
    chk("R3 busy chain bytes", expq.size(), 0);

    // R11 soft reset mid-transfer (completion of 0x90 left pending)
    mk_desc(11, 32'h0, 400, 30, F_SOP | F_EOP | F_OWN, 1);
    wr(2'd1, 32'hB0);
    repeat (12) @(negedge clk);
    wr(2'd0, 32'h3);
    rd(2'd0, v); chk("R11 reset bit reads 1", v, 32'h3);
    @(negedge clk);
    rd(2'd0, v); chk("R11 reset bit self-clears", v, 32'h1);
    repeat (3) @(negedge clk);
    rd(2'd3, v); chk("R11 status cleared", v, 32'h0);
    rd(2'd1, v); chk("R11 head cleared", v, 32'h0);
    rd(2'd2, v); chk("R11 completion cleared", v, 32'h0);
    chk("R11 stream quiet", {31'h0, tx_valid}, 32'h0);
    chk("R11 no write-back", dmem[47], F_SOP | F_EOP | F_OWN | 32'd30);
    expq.delete();

    // R12 enable cleared mid-chain
    mk_desc(12, 32'hD0, 500, 10, F_SOP | F_OWN, 1);
    mk_desc(13, 32'h0,  540, 3, F_EOP | F_OWN, 1);
    wr(2'd1, 32'hC0);
    repeat (4) @(negedge clk);
    wr(2'd0, 32'h0);
    for (int n = 0; n < 2000; n++) begin
      rd(2'd1, v);
      if (v == 32'hD0) break;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R12 paused at next", v, 32'hD0);
    chk("R12 current finished", dmem[51], F_SOP | 32'd10);
    chk("R12 next untouched", dmem[55], F_EOP | F_OWN | 32'd3);
    chk("R12 next bytes held", expq.size(), 3);
    wr(2'd0, 32'h1);
    wait_idle();
    chk("R12 resumed tail EOQ", dmem[55], F_EOP | F_EOQ | 32'd3);
    chk("R12 all bytes sent", expq.size(), 0);

    stall = 0;
    repeat (5) @(negedge clk);
    summary();
  end
endmodule